// File: doc/BRIEF.md
# Descriptor Pointer Fetch Queue

This block sits in front of one processing channel and holds the addresses of work descriptors that a host CPU has prepared in memory. The host launches work by writing a pointer into a 64-bit write-only register. Each accepted write adds one entry to an in-order queue of up to 24 pointers. The pointer can be 36 bits wide: a 4-bit upper field is held in a separate register that the host writes before the address or in the same write.

Whenever the channel is idle and not halted, the block removes the oldest pointer from the queue and hands it to the descriptor-fetch engine as a one-cycle start pulse. The channel then stays busy until the engine reports that the descriptor has finished.

A pointer of zero is treated as an error and stops the channel. Overflow is handled in two tiers. The first push into a full queue is dropped and raises a warning interrupt. A second drop before software clears that warning is fatal and halts the channel. Software restarts a halted channel with a continue pulse, which keeps the queue contents. A reset pulse clears the whole channel.

Top module: `desc_ptr_queue`

## Requirements
- R1: After reset, `fill_count` is 0, `fetch_start` is low, and all three interrupt flags and `halted` are low.
- R2: A write pushes a pointer only when `wr_be[0]` is set, and the address comes from `wr_data[31:0]`. Setting `wr_be[4]` stores `wr_data[35:32]` in the extension register, which resets to 0 and keeps its value until it is rewritten. A write without `wr_be[0]` leaves the queue unchanged.
- R3: With `ext_en` high, a pushed pointer is `{extension, address}`. If the same write also sets `wr_be[4]`, the new extension value is used. With `ext_en` low, the upper 4 bits of the pointer are 0.
- R4: `fill_count` reports the number of queued pointers, which never exceeds 24. An accepted push raises it by one on the next cycle.
- R5: When the channel is not busy, not halted and the queue is not empty, the oldest pointer is removed. One cycle later, `fetch_start` pulses high for one cycle with the pointer on `fetch_ptr`. The channel stays busy until `desc_done` is pulsed. Pointers leave in the order they were written.
- R6: If the removed pointer is zero, it is discarded and no `fetch_start` is given. `irq_zero_ptr` and `halted` are set.
- R7: A push into a full queue with no removal in the same cycle is dropped and sets `irq_single_ovf`. Dispatching continues.
- R8: A dropped push while `irq_single_ovf` is already set raises `irq_double_ovf` and `halted`. No pointer is dispatched while `halted` is high.
- R9: A push in the same cycle as a removal from a full queue is accepted without overflow, and `fill_count` stays at 24.
- R10: A `ctl_continue` pulse clears all three interrupt flags and `halted`. Dispatching resumes from the preserved queue contents, in order.
- R11: A `ctl_reset` pulse empties the queue, clears all flags, the busy state and the extension register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the pointer register |
| wr_data | input | 64 | Write data: [31:0] address, [35:32] extension, rest reserved |
| wr_be | input | 8 | Byte enables; bit 0 pushes, bit 4 loads the extension |
| ext_en | input | 1 | Enables the 4-bit pointer extension |
| desc_done | input | 1 | Pulse: current descriptor finished |
| ctl_continue | input | 1 | Pulse: clear flags and resume a halted channel |
| ctl_reset | input | 1 | Pulse: fully reset the channel and queue |
| fetch_start | output | 1 | One-cycle start pulse to the fetch engine |
| fetch_ptr | output | 36 | Descriptor pointer qualified by fetch_start |
| fill_count | output | 5 | Number of queued pointers |
| irq_single_ovf | output | 1 | First overflow warning, sticky |
| irq_double_ovf | output | 1 | Fatal second overflow, sticky |
| irq_zero_ptr | output | 1 | Zero pointer popped, sticky |
| halted | output | 1 | Channel stopped by a fatal error |

## Verification
A host push and an engine-side removal can land in the same cycle. This matters most when the queue holds 24 pointers, because the removal then decides whether the push is an overflow. The bench provokes this case by filling the queue while the channel is busy. It then pulses `desc_done` and drives a push in the following cycle, which is the cycle in which the removal happens. The pass condition is that `fill_count` stays at 24, `irq_single_ovf` stays low, and the pushed pointer comes out last in the order that follows.

// File: rtl/dpq_pkg.sv
`timescale 1ns/1ps
package dpq_pkg;
  localparam int REG_W      = 64;
  localparam int BE_W       = REG_W / 8;
  localparam int PUSH_LANE  = 0;

  typedef struct packed {
    logic single_ovf;
    logic double_ovf;
    logic zero_ptr;
  } dpq_flags_t;
endpackage

// File: rtl/dpq_rst_sync.sv
`timescale 1ns/1ps
module dpq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/dpq_wr_decode.sv
`timescale 1ns/1ps
module dpq_wr_decode
  import dpq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int EXT_W  = 4,
  localparam int PTR_W    = ADDR_W + EXT_W,
  localparam int EXT_LANE = ADDR_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [BE_W-1:0]  wr_be,
  input  logic             ext_en,
  input  logic             ctl_reset,
  output logic             push_req,
  output logic [PTR_W-1:0] push_ptr
);
  logic [EXT_W-1:0] ext_q, ext_d;
  logic             ext_load;
  logic [EXT_W-1:0] ext_fresh;

  assign ext_load  = wr_en && wr_be[EXT_LANE];
  assign ext_fresh = wr_data[PTR_W-1:ADDR_W];

  always_comb begin
    ext_d = ext_q;
    if (ctl_reset)     ext_d = '0;
    else if (ext_load) ext_d = ext_fresh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= '0;
    else        ext_q <= ext_d;
  end

  assign push_req = wr_en && wr_be[PUSH_LANE];

  always_comb begin
    push_ptr = {{EXT_W{1'b0}}, wr_data[ADDR_W-1:0]};
    if (ext_en) begin
      push_ptr[PTR_W-1:ADDR_W] = ext_load ? ext_fresh : ext_q;
    end
  end

  AST_EXT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset |=> (ext_q == '0)); // R11
endmodule

// File: rtl/dpq_fifo.sv
`timescale 1ns/1ps
module dpq_fifo #(
  parameter int DEPTH = 24,
  parameter int WIDTH = 36,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [IDX_W-1:0] wr_idx_q, wr_idx_d, rd_idx_q, rd_idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  always_comb begin
    wr_idx_d = wr_idx_q;
    rd_idx_d = rd_idx_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_idx_d = '0;
      rd_idx_d = '0;
      cnt_d    = '0;
    end else begin
      if (push) wr_idx_d = wrap_inc(wr_idx_q);
      if (pop)  rd_idx_d = wrap_inc(rd_idx_q);
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_idx_q <= wr_idx_d;
      rd_idx_q <= rd_idx_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = push && !flush && (wr_idx_q == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) mem[g] <= wdata;
    end
  end

  assign head  = mem[rd_idx_q];
  assign count = cnt_q;

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R4
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0)); // R5
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0)); // R11
endmodule

// File: rtl/dpq_ctrl.sv
`timescale 1ns/1ps
module dpq_ctrl
  import dpq_pkg::*;
#(
  parameter int DEPTH = 24,
  parameter int PTR_W = 36,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic [PTR_W-1:0] head_ptr,
  input  logic [CNT_W-1:0] count,
  input  logic             desc_done,
  input  logic             ctl_continue,
  input  logic             ctl_reset,
  output logic             push_ok,
  output logic             pop,
  output logic             flush,
  output logic             fetch_start,
  output logic [PTR_W-1:0] fetch_ptr,
  output dpq_flags_t       flags,
  output logic             halted
);
  dpq_flags_t       flags_q, flags_d, flags_base;
  logic             busy_q, busy_d;
  logic             start_q, start_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             full, overflow, zero_hit, dispatch;

  assign halted   = flags_q.double_ovf | flags_q.zero_ptr;
  assign full     = (count == CNT_W'(DEPTH));
  assign pop      = !busy_q && !halted && (count != '0) && !ctl_reset;
  assign zero_hit = pop && (head_ptr == '0);
  assign dispatch = pop && !zero_hit;
  assign push_ok  = push_req && (!full || pop) && !ctl_reset;
  assign overflow = push_req && full && !pop && !ctl_reset;
  assign flush    = ctl_reset;

  always_comb begin
    flags_base = ctl_continue ? '0 : flags_q;
    flags_d    = flags_base;
    if (ctl_reset) begin
      flags_d = '0;
    end else begin
      flags_d.single_ovf = flags_base.single_ovf | overflow;
      flags_d.double_ovf = flags_base.double_ovf | (overflow && flags_q.single_ovf);
      flags_d.zero_ptr   = flags_base.zero_ptr | zero_hit;
    end
  end

  always_comb begin
    busy_d  = busy_q;
    start_d = 1'b0;
    ptr_d   = ptr_q;
    if (ctl_reset) begin
      busy_d = 1'b0;
    end else if (dispatch) begin
      busy_d  = 1'b1;
      start_d = 1'b1;
      ptr_d   = head_ptr;
    end else if (desc_done) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      ptr_q   <= '0;
    end else begin
      flags_q <= flags_d;
      busy_q  <= busy_d;
      start_q <= start_d;
      ptr_q   <= ptr_d;
    end
  end

  assign fetch_start = start_q;
  assign fetch_ptr   = ptr_q;
  assign flags       = flags_q;

  AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q); // R5
  AST_FETCH_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (ptr_q != '0)); // R6
  AST_NO_DISPATCH_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> !start_q); // R8
  AST_DOUBLE_AFTER_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q.double_ovf) |-> $past(flags_q.single_ovf)); // R8
  AST_NO_OVERFLOW_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> !push_ok); // R7
endmodule

// File: rtl/desc_ptr_queue.sv
`timescale 1ns/1ps
module desc_ptr_queue
  import dpq_pkg::*;
#(
  parameter int DEPTH  = 24,
  parameter int ADDR_W = 32,
  parameter int EXT_W  = 4,
  localparam int PTR_W = ADDR_W + EXT_W,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [63:0]      wr_data,
  input  logic [7:0]       wr_be,
  input  logic             ext_en,
  input  logic             desc_done,
  input  logic             ctl_continue,
  input  logic             ctl_reset,
  output logic             fetch_start,
  output logic [PTR_W-1:0] fetch_ptr,
  output logic [CNT_W-1:0] fill_count,
  output logic             irq_single_ovf,
  output logic             irq_double_ovf,
  output logic             irq_zero_ptr,
  output logic             halted
);
  logic             rst_n_i;
  logic             push_req, push_ok, pop, flush;
  logic [PTR_W-1:0] push_ptr, head_ptr;
  dpq_flags_t       flags;

  dpq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  dpq_wr_decode #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wr_be     (wr_be),
    .ext_en    (ext_en),
    .ctl_reset (ctl_reset),
    .push_req  (push_req),
    .push_ptr  (push_ptr)
  );

  dpq_fifo #(.DEPTH(DEPTH), .WIDTH(PTR_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n_i),
    .flush (flush),
    .push  (push_ok),
    .pop   (pop),
    .wdata (push_ptr),
    .head  (head_ptr),
    .count (fill_count)
  );

  dpq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .push_req     (push_req),
    .head_ptr     (head_ptr),
    .count        (fill_count),
    .desc_done    (desc_done),
    .ctl_continue (ctl_continue),
    .ctl_reset    (ctl_reset),
    .push_ok      (push_ok),
    .pop          (pop),
    .flush        (flush),
    .fetch_start  (fetch_start),
    .fetch_ptr    (fetch_ptr),
    .flags        (flags),
    .halted       (halted)
  );

  assign irq_single_ovf = flags.single_ovf;
  assign irq_double_ovf = flags.double_ovf;
  assign irq_zero_ptr   = flags.zero_ptr;

  AST_SIMUL_FULL_OK: assert property (@(posedge clk) disable iff (!rst_n_i)
    (push_req && pop && fill_count == CNT_W'(DEPTH)) |=> !$rose(irq_single_ovf)); // R9
endmodule

// File: tb/desc_ptr_queue_test.sv
`timescale 1ns/1ps
module desc_ptr_queue_test;
  localparam int DEPTH = 24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, ext_en, desc_done, ctl_continue, ctl_reset;
  logic [63:0] wr_data;
  logic [7:0]  wr_be;
  logic        fetch_start, irq_single_ovf, irq_double_ovf, irq_zero_ptr, halted;
  logic [35:0] fetch_ptr;
  logic [4:0]  fill_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  desc_ptr_queue uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_be(wr_be),
    .ext_en(ext_en), .desc_done(desc_done), .ctl_continue(ctl_continue),
    .ctl_reset(ctl_reset), .fetch_start(fetch_start), .fetch_ptr(fetch_ptr),
    .fill_count(fill_count), .irq_single_ovf(irq_single_ovf),
    .irq_double_ovf(irq_double_ovf), .irq_zero_ptr(irq_zero_ptr), .halted(halted)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [31:0] a, input logic [3:0] e, input logic [7:0] be);
    wr_en   = 1'b1;
    wr_data = {28'h0, e, a};
    wr_be   = be;
    tick();
    wr_en = 1'b0;
    wr_be = 8'h00;
  endtask

  task automatic done_pulse;
    desc_done = 1'b1; tick(); desc_done = 1'b0;
  endtask

  task automatic cont_pulse;
    ctl_continue = 1'b1; tick(); ctl_continue = 1'b0;
  endtask

  task automatic expect_fetch(input logic [35:0] exp, input string req);
    chk(fetch_start == 1'b1, req, 64'(fetch_start), 64'd1);
    chk(fetch_ptr == exp, req, 64'(fetch_ptr), 64'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_data = '0; wr_be = '0; ext_en = 0;
    desc_done = 0; ctl_continue = 0; ctl_reset = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    chk(fill_count == 0, "R1 count", 64'(fill_count), 0);
    chk(!fetch_start && !halted, "R1 start/halt", {62'd0, fetch_start, halted}, 0);
    chk({irq_single_ovf, irq_double_ovf, irq_zero_ptr} == 3'b0, "R1 irq",
        64'({irq_single_ovf, irq_double_ovf, irq_zero_ptr}), 0);

    // R5 single dispatch timing
    push(32'h0000_0A00, 4'h0, 8'h01);
    chk(fill_count == 1, "R4 count after push", 64'(fill_count), 1);
    chk(!fetch_start, "R5 no early start", 64'(fetch_start), 0);
    tick();
    expect_fetch(36'h0_0000_0A00, "R5 dispatch");
    chk(fill_count == 0, "R5 count after pop", 64'(fill_count), 0);
    tick();
    chk(!fetch_start, "R5 one-cycle pulse", 64'(fetch_start), 0);

    // R4 fill sweep while busy
    for (int i = 0; i < DEPTH; i++) begin
      push(32'(100 + i), 4'h0, 8'h01);
      chk(fill_count == 5'(i + 1), "R4 fill", 64'(fill_count), 64'(i + 1));
    end

    // R7 first overflow
    push(32'h0000_DEAD, 4'h0, 8'h01);
    chk(irq_single_ovf, "R7 single", 64'(irq_single_ovf), 1);
    chk(!halted && fill_count == 24, "R7 continues", 64'({halted, fill_count}), 64'(24));
    // R8 second overflow
    push(32'h0000_BEEF, 4'h0, 8'h01);
    chk(irq_double_ovf && halted, "R8 double", 64'({irq_double_ovf, halted}), 3);
    done_pulse();
    tick(); tick();
    chk(!fetch_start && fill_count == 24, "R8 no dispatch halted",
        64'({fetch_start, fill_count}), 64'(24));

    // R10 continue resumes preserved contents
    cont_pulse();
    chk({irq_single_ovf, irq_double_ovf, halted} == 3'b0, "R10 cleared",
        64'({irq_single_ovf, irq_double_ovf, halted}), 0);
    tick();
    expect_fetch(36'd100, "R10 resume order");
    chk(fill_count == 23, "R10 count", 64'(fill_count), 23);

    // R9 push concurrent with pop at full
    push(32'd124, 4'h0, 8'h01);
    chk(fill_count == 24, "R9 refilled", 64'(fill_count), 24);
    done_pulse();
    push(32'd125, 4'h0, 8'h01);
    expect_fetch(36'd101, "R9 pop in push cycle");
    chk(fill_count == 24 && !irq_single_ovf, "R9 no overflow",
        64'({irq_single_ovf, fill_count}), 64'(24));

    // R5 FIFO order drain
    for (int j = 102; j <= 125; j++) begin
      done_pulse();
      tick();
      expect_fetch(36'(j), "R5 order");
    end
    chk(fill_count == 0, "R4 drained", 64'(fill_count), 0);
    done_pulse();

    // R2 missing lane 0 pushes nothing, lane 4 latches extension
    push(32'h0000_0033, 4'h3, 8'hFE);
    tick();
    chk(!fetch_start && fill_count == 0, "R2 ignored write",
        64'({fetch_start, fill_count}), 0);
    ext_en = 1'b1;
    push(32'h0000_0055, 4'h0, 8'h01);
    tick();
    expect_fetch(36'h3_0000_0055, "R2 latched ext");
    done_pulse();
    // R3 same-write extension
    push(32'h0000_0066, 4'h9, 8'h11);
    tick();
    expect_fetch(36'h9_0000_0066, "R3 same write ext");
    done_pulse();
    ext_en = 1'b0;
    push(32'h0000_0077, 4'h0, 8'h01);
    tick();
    expect_fetch(36'h0_0000_0077, "R3 ext disabled");
    done_pulse();

    // R6 zero pointer
    push(32'h0, 4'h0, 8'h01);
    tick();
    chk(irq_zero_ptr && halted, "R6 zero flag", 64'({irq_zero_ptr, halted}), 3);
    chk(!fetch_start && fill_count == 0, "R6 discarded",
        64'({fetch_start, fill_count}), 0);
    push(32'h0000_0088, 4'h0, 8'h01);
    tick();
    chk(!fetch_start && fill_count == 1, "R6 stays halted",
        64'({fetch_start, fill_count}), 1);
    cont_pulse();
    chk(!irq_zero_ptr && !halted, "R10 zero cleared", 64'({irq_zero_ptr, halted}), 0);
    tick();
    expect_fetch(36'h0_0000_0088, "R10 resume after zero");

    // R11 channel reset
    push(32'd1, 4'h0, 8'h01);
    push(32'd2, 4'h0, 8'h01);
    push(32'd3, 4'hF, 8'h11);
    chk(fill_count == 3, "R11 pre-fill", 64'(fill_count), 3);
    ctl_reset = 1'b1; tick(); ctl_reset = 1'b0;
    chk(fill_count == 0, "R11 emptied", 64'(fill_count), 0);
    ext_en = 1'b1;
    push(32'h0000_0099, 4'h0, 8'h01);
    tick();
    expect_fetch(36'h0_0000_0099, "R11 idle and ext cleared");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule